// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This unit sits beside the receive and transmit queues of a serial port and turns their fill levels and error events into one interrupt line. Every cycle it forms a live status word from the two queue counts and two programmable fill thresholds. It then folds the low live flags, the transmit-threshold flag and six event pulses into a sticky status register. Bits of the sticky register stay set until software clears them.

Software drives a small write port. One select value sets mask bits and another clears them. A third select value names the mask itself and is ignored. A fourth clears sticky bits written as ones, and two more load the receive and transmit thresholds. The interrupt output is a flop that goes high when any sticky bit is also enabled in the mask.

Top module: `uart_irq_unit`

## Requirements
- R1: `status_live` is combinational from the counts and the current thresholds. bit0 = rx count >= rx threshold, bit1 = rx count is 0, bit2 = rx count equals FIFO_DEPTH, bit3 = tx count is 0, bit4 = tx count equals FIFO_DEPTH, bit13 = tx count >= tx threshold. All other bits are 0.
- R2: At each clock edge, live bits 4:0 are ORed into sticky bits 4:0.
- R3: Live bit13 sets sticky bit10 at the next edge. The sticky word is 13 bits wide and has no bit13.
- R4: Event pulses set sticky bits at the next edge: rx overrun bit5, framing error bit6, parity error bit7, rx timeout bit8, modem status bit9, tx overrun bit12. Sticky bit11 is always 0.
- R5: Writes with select 0 (enable) OR `wr_data` into the mask. Select 1 (disable) clears the mask bits written as 1. Select 2 (mask) leaves the mask unchanged. Each takes effect at the next edge.
- R6: A write with select 3 (clear) clears the sticky bits written as 1 at the next edge. Sticky bits written as 0 keep their value.
- R7: If a set condition and a clear hit the same sticky bit in one cycle, the bit is set after the edge.
- R8: `irq` is a flop that takes the OR of (mask AND sticky) as those registers stood before the edge. It therefore lags any change in them by one clock.
- R9: Reset (`rst_n` low, asynchronous) makes the mask, sticky status and `irq` zero, and sets both thresholds to 32.
- R10: Select 4 loads `wr_data[CNT_W-1:0]` into the rx threshold and select 5 loads it into the tx threshold. The new value is used by `status_live` after the edge. The comparison is inclusive.
- R11: Select codes 6 and 7 change neither the mask, the thresholds nor the sticky status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive queue fill level |
| tx_count | input | CNT_W | Transmit queue fill level |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overrun | input | 1 | Transmit overrun pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 13 | Write data |
| status_live | output | 14 | Live status word |
| status_sticky | output | 13 | Sticky interrupt status |
| irq_mask | output | 13 | Interrupt enable mask |
| irq | output | 1 | Level interrupt output |

## Verification
Results are due at different times:
- `status_live` is due in the same cycle as a count change.
- Sticky bits, mask updates and threshold loads are due one edge after the write or event that causes them.
- `irq` is due one edge after those, so two edges after the original stimulus.

The bench drives inputs shortly after the falling edge and compares against its own reference model at each falling edge. That reference model steps on rising edges and holds `irq` back by exactly one modelled edge. Directed checks sample at a falling edge, so each one sees precisely one rising edge after its stimulus. Counts for the live word are compared just after they are driven.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int LIVE_W = 14;
  localparam int STK_W  = 13;
  localparam int EV_W   = 6;

  // live word positions
  localparam int LV_RX_LVL   = 0;
  localparam int LV_RX_EMPTY = 1;
  localparam int LV_RX_FULL  = 2;
  localparam int LV_TX_EMPTY = 3;
  localparam int LV_TX_FULL  = 4;
  localparam int LV_TX_LVL   = 13;

  // sticky word positions
  localparam int SK_TX_LVL  = 10;
  localparam int SK_GAP     = 11;
  localparam int SK_RX_OVR  = 5;
  localparam int SK_FRAME   = 6;
  localparam int SK_PARITY  = 7;
  localparam int SK_TIMEOUT = 8;
  localparam int SK_MODEM   = 9;
  localparam int SK_TX_OVR  = 12;

  typedef enum logic [2:0] {
    SEL_ENABLE  = 3'd0,
    SEL_DISABLE = 3'd1,
    SEL_MASK    = 3'd2,
    SEL_CLEAR   = 3'd3,
    SEL_RX_TRIG = 3'd4,
    SEL_TX_TRIG = 3'd5
  } wr_sel_e;

  // event vector order: rx_ovr, frame, parity, timeout, modem, tx_ovr
  function automatic logic [STK_W-1:0] fold_live(input logic [LIVE_W-1:0] lv,
                                                 input logic [EV_W-1:0] ev);
    logic [STK_W-1:0] s;
    s = '0;
    s[4:0]        = lv[4:0];
    s[SK_TX_LVL]  = lv[LV_TX_LVL];
    s[SK_RX_OVR]  = ev[0];
    s[SK_FRAME]   = ev[1];
    s[SK_PARITY]  = ev[2];
    s[SK_TIMEOUT] = ev[3];
    s[SK_MODEM]   = ev[4];
    s[SK_TX_OVR]  = ev[5];
    return s;
  endfunction
endpackage

// File: rtl/uirq_live.sv
module uirq_live import uirq_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_trig_i,
  input  logic [CNT_W-1:0]  tx_trig_i,
  output logic [LIVE_W-1:0] live_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [1:0][CNT_W-1:0] cnt;
  logic [1:0][CNT_W-1:0] trig;
  logic [1:0] at_lvl, is_empty, is_full;

  assign cnt  = {tx_cnt_i, rx_cnt_i};
  assign trig = {tx_trig_i, rx_trig_i};

  // same flag logic for both directions: index 0 = rx, 1 = tx
  for (genvar g = 0; g < 2; g++) begin : g_dir
    assign at_lvl[g]   = cnt[g] >= trig[g];
    assign is_empty[g] = cnt[g] == '0;
    assign is_full[g]  = cnt[g] == FULL_CNT;
  end

  always_comb begin
    live_o              = '0;
    live_o[LV_RX_LVL]   = at_lvl[0];
    live_o[LV_RX_EMPTY] = is_empty[0];
    live_o[LV_RX_FULL]  = is_full[0];
    live_o[LV_TX_EMPTY] = is_empty[1];
    live_o[LV_TX_FULL]  = is_full[1];
    live_o[LV_TX_LVL]   = at_lvl[1];
  end
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs import uirq_pkg::*; #(
  parameter int CNT_W    = 7,
  parameter int TRIG_RST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [STK_W-1:0] wr_data_i,
  output logic [STK_W-1:0] mask_o,
  output logic [STK_W-1:0] clr_o,
  output logic [CNT_W-1:0] rx_trig_o,
  output logic [CNT_W-1:0] tx_trig_o
);
  wr_sel_e sel;
  logic do_en, do_dis, do_clr, do_rxt, do_txt;
  logic [STK_W-1:0] mask_q;
  logic [CNT_W-1:0] rxt_q, txt_q;

  assign sel    = wr_sel_e'(wr_sel_i);
  assign do_en  = wr_en_i && sel == SEL_ENABLE;
  assign do_dis = wr_en_i && sel == SEL_DISABLE;
  assign do_clr = wr_en_i && sel == SEL_CLEAR;
  assign do_rxt = wr_en_i && sel == SEL_RX_TRIG;
  assign do_txt = wr_en_i && sel == SEL_TX_TRIG;

  assign clr_o = do_clr ? wr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rxt_q  <= CNT_W'(TRIG_RST);
      txt_q  <= CNT_W'(TRIG_RST);
    end else begin
      if (do_en)  mask_q <= mask_q | wr_data_i;
      if (do_dis) mask_q <= mask_q & ~wr_data_i;
      if (do_rxt) rxt_q  <= wr_data_i[CNT_W-1:0];
      if (do_txt) txt_q  <= wr_data_i[CNT_W-1:0];
    end
  end

  assign mask_o    = mask_q;
  assign rx_trig_o = rxt_q;
  assign tx_trig_o = txt_q;

  p_enable_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd0) |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));
  p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd1) |=> ((mask_q & $past(wr_data_i)) == '0));
  p_mask_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd2) |=> $stable(mask_q));
  p_spare_sel_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i[2:1] == 2'b11) |=> ($stable(mask_q) && $stable(rxt_q) && $stable(txt_q)));
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky import uirq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE_W-1:0] live_i,
  input  logic [EV_W-1:0]   ev_i,
  input  logic [STK_W-1:0]  clr_i,
  output logic [STK_W-1:0]  sticky_o
);
  logic [STK_W-1:0] set_vec;
  logic [STK_W-1:0] sticky_q;

  assign set_vec = fold_live(live_i, ev_i);

  // set is applied after clear so a collision leaves the bit set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~clr_i) | set_vec;
  end

  assign sticky_o = sticky_q;

  p_live_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q[4:0] & $past(live_i[4:0])) == $past(live_i[4:0])));
  p_tx_level_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_i[LV_TX_LVL] |=> sticky_q[SK_TX_LVL]);
  p_frame_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i[1] |=> sticky_q[SK_FRAME]);
  p_gap_bit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_q[SK_GAP]);
  p_clear_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[SK_FRAME] && !ev_i[1]) |=> !sticky_q[SK_FRAME]);
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i[0] && clr_i[SK_RX_OVR]) |=> sticky_q[SK_RX_OVR]);
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit import uirq_pkg::*; #(
  parameter int FIFO_DEPTH = 64,
  parameter int TRIG_RST   = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ev_rx_overrun,
  input  logic              ev_rx_timeout,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_modem,
  input  logic              ev_tx_overrun,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [STK_W-1:0]  wr_data,
  output logic [LIVE_W-1:0] status_live,
  output logic [STK_W-1:0]  status_sticky,
  output logic [STK_W-1:0]  irq_mask,
  output logic              irq
);
  logic [CNT_W-1:0] rx_trig, tx_trig;
  logic [STK_W-1:0] clr_vec;
  logic [EV_W-1:0]  ev_vec;
  logic             irq_next;
  logic             irq_q;

  assign ev_vec = {ev_tx_overrun, ev_modem, ev_rx_timeout,
                   ev_parity_err, ev_frame_err, ev_rx_overrun};

  uirq_regs #(.CNT_W(CNT_W), .TRIG_RST(TRIG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .mask_o(irq_mask), .clr_o(clr_vec),
    .rx_trig_o(rx_trig), .tx_trig_o(tx_trig)
  );

  uirq_live #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
    .rx_cnt_i(rx_count), .tx_cnt_i(tx_count),
    .rx_trig_i(rx_trig), .tx_trig_i(tx_trig), .live_o(status_live)
  );

  uirq_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .live_i(status_live), .ev_i(ev_vec),
    .clr_i(clr_vec), .sticky_o(status_sticky)
  );

  assign irq_next = |(irq_mask & status_sticky);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next;
  end

  assign irq = irq_q;

  p_irq_lags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(irq_mask & status_sticky))));
  p_reset_clean_r9: assert property (@(posedge clk)
    !rst_n |-> (irq_mask == '0 && status_sticky == '0 && !irq));
endmodule

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;
  localparam int DEPTH = 64;
  localparam int CW    = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic ev_rx_overrun = 0, ev_rx_timeout = 0, ev_frame_err = 0;
  logic ev_parity_err = 0, ev_modem = 0, ev_tx_overrun = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = '0;
  logic [12:0] wr_data = '0;
  logic [13:0] status_live;
  logic [12:0] status_sticky, irq_mask;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_mask = 0, m_stk = 0, m_rxt = 32, m_txt = 32;
  bit m_irq = 0;

  always #4 clk = ~clk;

  uart_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .ev_rx_overrun(ev_rx_overrun), .ev_rx_timeout(ev_rx_timeout),
    .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err),
    .ev_modem(ev_modem), .ev_tx_overrun(ev_tx_overrun),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_live(status_live), .status_sticky(status_sticky),
    .irq_mask(irq_mask), .irq(irq)
  );

  function automatic int ref_live(int rc, int tc, int rt, int tt);
    int v = 0;
    if (rc >= rt)    v += 1;
    if (rc == 0)     v += 2;
    if (rc == DEPTH) v += 4;
    if (tc == 0)     v += 8;
    if (tc == DEPTH) v += 16;
    if (tc >= tt)    v += 8192;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model steps on rising edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_stk = 0; m_rxt = 32; m_txt = 32; m_irq = 0;
    end else begin
      int lv, setv, clrv;
      lv   = ref_live(int'(rx_count), int'(tx_count), m_rxt, m_txt);
      setv = (lv % 32) + (((lv / 8192) % 2) * 1024);
      if (ev_rx_overrun) setv |= 32;
      if (ev_frame_err)  setv |= 64;
      if (ev_parity_err) setv |= 128;
      if (ev_rx_timeout) setv |= 256;
      if (ev_modem)      setv |= 512;
      if (ev_tx_overrun) setv |= 4096;
      clrv  = (wr_en && wr_sel == 3) ? int'(wr_data) : 0;
      m_irq = (m_mask & m_stk) != 0;
      m_stk = ((m_stk & ~clrv) | setv) & 8191;
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_mask = m_mask | int'(wr_data);
          3'd1: m_mask = m_mask & ~int'(wr_data);
          3'd4: m_rxt  = int'(wr_data) % 128;
          3'd5: m_txt  = int'(wr_data) % 128;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R1 live", int'(status_live), ref_live(int'(rx_count), int'(tx_count), m_rxt, m_txt));
      chk("R2 sticky", int'(status_sticky), m_stk);
      chk("R5 mask", int'(irq_mask), m_mask);
      chk("R8 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic cyc();
    @(negedge clk); #2;
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 13'(data);
    cyc();
    wr_en = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0;
    cyc();
    // R9: reset state and threshold 32
    chk("R9 mask", int'(irq_mask), 0);
    chk("R9 sticky", int'(status_sticky), 0);
    chk("R9 irq", int'(irq), 0);
    rx_count = 31; #1;
    chk("R9 rx threshold below", int'(status_live[0]), 0);
    rx_count = 32; #1;
    chk("R9 rx threshold at", int'(status_live[0]), 1);
    rx_count = 0; tx_count = 32; #1;
    chk("R9 tx threshold at", int'(status_live[13]), 1);
    tx_count = 0;
    rst_n = 1;
    cyc(); cyc();
    // R1 patterns
    chk("R1 both empty", int'(status_live), 'h000A);
    rx_count = 64; tx_count = 64; #1;
    chk("R1 both full", int'(status_live), 'h2015);
    rx_count = 10; tx_count = 5; #1;
    chk("R1 mid level", int'(status_live), 0);
    cyc();
    // R6 clear all
    wr(3, 'h1FFF);
    chk("R6 clear all", int'(status_sticky), 0);
    // R3 tx threshold folds into bit10
    tx_count = 40; cyc();
    chk("R3 tx level to bit10", int'(status_sticky), 'h0400);
    tx_count = 5; wr(3, 'h1FFF);
    chk("R6 clear bit10", int'(status_sticky), 0);
    // R4 events
    ev_frame_err = 1; cyc(); ev_frame_err = 0;
    chk("R4 frame bit6", int'(status_sticky), 'h0040);
    ev_tx_overrun = 1; ev_modem = 1; cyc();
    ev_tx_overrun = 0; ev_modem = 0;
    chk("R4 modem and tx overrun", int'(status_sticky), 'h1240);
    ev_rx_overrun = 1; ev_rx_timeout = 1; cyc();
    ev_rx_overrun = 0; ev_rx_timeout = 0;
    chk("R4 overrun and timeout, bit11 clear", int'(status_sticky), 'h1360);
    wr(3, 'h0120);
    // R6 partial clear
    wr(3, 'h0200);
    chk("R6 partial clear", int'(status_sticky), 'h1040);
    // R7 set wins over clear
    ev_parity_err = 1; wr_en = 1; wr_sel = 3; wr_data = 'h1080;
    cyc();
    wr_en = 0; ev_parity_err = 0;
    chk("R7 set wins", int'(status_sticky), 'h00C0);
    // R5 / R8 mask and irq timing
    wr(0, 'h0040);
    chk("R5 enable", int'(irq_mask), 'h0040);
    chk("R8 irq not yet", int'(irq), 0);
    cyc();
    chk("R8 irq one clock later", int'(irq), 1);
    wr(2, 'h1FFF);
    chk("R5 mask write ignored", int'(irq_mask), 'h0040);
    wr(0, 'h0081);
    chk("R5 enable accumulates", int'(irq_mask), 'h00C1);
    wr(1, 'h00C0);
    chk("R5 disable", int'(irq_mask), 'h0001);
    chk("R8 irq still high", int'(irq), 1);
    cyc();
    chk("R8 irq drops", int'(irq), 0);
    // R10 thresholds
    wr(4, 4);
    rx_count = 4; #1;
    chk("R10 rx at new threshold", int'(status_live[0]), 1);
    rx_count = 3; #1;
    chk("R10 rx below new threshold", int'(status_live[0]), 0);
    wr(5, 2);
    tx_count = 2; #1;
    chk("R10 tx at new threshold", int'(status_live[13]), 1);
    tx_count = 1; #1;
    chk("R10 tx below new threshold", int'(status_live[13]), 0);
    // R11 spare selects
    wr(6, 'h1FFF);
    wr(7, 'h1FFF);
    chk("R11 mask unchanged", int'(irq_mask), 'h0001);
    #1;
    chk("R11 rx threshold unchanged", int'(status_live[0]), 0);
    // mixed stimulus against the model
    for (int i = 0; i < 2000; i++) begin
      rx_count      = CW'($urandom_range(0, DEPTH));
      tx_count      = CW'($urandom_range(0, DEPTH));
      ev_rx_overrun = ($urandom % 8) == 0;
      ev_rx_timeout = ($urandom % 8) == 0;
      ev_frame_err  = ($urandom % 8) == 0;
      ev_parity_err = ($urandom % 8) == 0;
      ev_modem      = ($urandom % 8) == 0;
      ev_tx_overrun = ($urandom % 8) == 0;
      wr_en   = ($urandom % 3) == 0;
      wr_sel  = 3'($urandom % 8);
      wr_data = 13'($urandom % 8192);
      if (wr_sel >= 4 && wr_sel <= 5) wr_data = 13'($urandom_range(0, 70));
      cyc();
    end
    wr_en = 0;
    cyc();
    finish_up();
  end
endmodule